// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Thresholds

This block is a first-in-first-out buffer that connects two unrelated clock domains. A producer pushes words on the write clock and a consumer pops them on the read clock. The two clocks can run at any rates. Word order is kept across the crossing. Each side sees status flags that are computed in its own domain from a synchronized copy of the other side's pointer. The write side gets full, half-full and almost-full. The read side gets empty and almost-empty.

Two offset registers set where the almost-empty and almost-full flags switch. While master reset is active, both offsets take one preset value. Three strap inputs choose that preset from eight candidates. After reset, software-free configuration logic can rewrite both offsets by shifting bits into a serial input on the write clock. Master reset also returns both pointers to the first storage location.

Top module: `dcfifo_pflag`

## Requirements
- R1: After master reset `rst_n` is released, the FIFO reads as empty. `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0 and `half_full`=0. Both pointers are at location 0, even if words were stored before the reset.
- R2: Words come out in the order they were written. A read accepted on a rising `rclk` edge places its word on `rdata` at that edge.
- R3: A write while `full` is 1 is dropped. No stored word is overwritten and the write pointer does not move.
- R4: A read while `empty` is 1 is dropped. `rdata` and the read pointer do not change.
- R5: `empty` is 1 when the read side counts zero stored words. `full` is 1 when the write side counts 2^AW stored words.
- R6: `half_full` is 1 when the write side counts more than 2^(AW-1) stored words.
- R7: `almost_empty` is 1 when the read-side word count is less than or equal to the almost-empty offset.
- R8: `almost_full` is 1 when the write-side word count is greater than or equal to 2^AW minus the almost-full offset.
- R9: During master reset, and for two write-clock cycles after its release, both offsets load a preset. The preset index is {`cfg_mode`, `preset_sel[1]`, `preset_sel[0]`}. Index n gives (8·2^n)−1, clipped to 2^AW−1.
- R10: On each rising `wclk` edge where `shift_en` and `cfg_mode` are both 1, one bit of `shift_din` is taken. The first AW bits form the almost-empty offset, least significant bit first. The next AW bits form the almost-full offset in the same way. When `shift_en` is 1 and `cfg_mode` is 0, the offsets are not changed.
- R11: Pointers cross domains as Gray codes. Each registered Gray pointer changes by at most one bit per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Master reset, asynchronous, active low, covers both domains |
| wclk | input | 1 | Write clock |
| we | input | 1 | Write request |
| wdata | input | DW | Word to store |
| preset_sel | input | 2 | Low two bits of the preset index, sampled during reset |
| cfg_mode | input | 1 | Preset index MSB during reset; also enables serial loading |
| shift_en | input | 1 | Serial offset load enable |
| shift_din | input | 1 | Serial offset data bit |
| rclk | input | 1 | Read clock |
| re | input | 1 | Read request |
| rdata | output | DW | Word most recently read |
| empty | output | 1 | No word stored (read domain) |
| almost_empty | output | 1 | Word count within the almost-empty offset (read domain) |
| full | output | 1 | Every location used (write domain) |
| almost_full | output | 1 | Word count within the almost-full offset of capacity (write domain) |
| half_full | output | 1 | More than half of capacity used (write domain) |

## Verification
The bench builds the block with AW=6 and DW=8, which gives 64 locations. With that depth, a full fill, an overflow attempt and a full drain each take only a few hundred cycles. The small depth also brings the preset clipping within reach: indices 3 to 7 all collapse to 63, so an almost-full threshold of one word can be observed. Index 2 (31) and serial values 3 and 10 show the thresholds moving away from both boundaries. The two clocks run at 10 ns and 13 ns periods, so their edges never line up.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    function automatic logic [31:0] bin2gray(logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // preset offset: (8 << idx) - 1, limited to depth - 1
    function automatic int preset_offset(logic [2:0] idx, int depth);
        int v;
        v = (8 << idx) - 1;
        return (v > depth - 1) ? depth - 1 : v;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [2:0]    psel,
    input  logic          cfg_mode,
    input  logic          shift_en,
    input  logic          shift_din,
    input  logic [AW:0]   rgray_s,
    output logic          wen,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          afull,
    output logic          half,
    output logic [AW-1:0] aeoff
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam int CW    = $clog2(2 * AW);

    typedef struct packed {
        logic [1:0]    hold;
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full;
        logic          afull;
        logic          half;
        logic [AW-1:0] aeoff;
        logic [AW-1:0] afoff;
        logic [CW-1:0] bitcnt;
    } wr_st_t;

    wr_st_t st_d, st_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] cnt;

    always_comb begin
        st_d      = st_q;
        st_d.hold = {st_q.hold[0], 1'b1};
        wen       = we & ~st_q.full;
        st_d.bin  = st_q.bin + PW'(wen);
        st_d.gray = PW'(dcf_pkg::bin2gray(32'(st_d.bin)));
        rbin      = PW'(dcf_pkg::gray2bin(32'(rgray_s)));
        cnt       = st_d.bin - rbin;
        st_d.full  = (cnt == PW'(DEPTH));
        st_d.afull = (cnt >= PW'(DEPTH) - PW'(st_q.afoff));
        st_d.half  = (cnt > PW'(DEPTH / 2));
        if (!st_q.hold[1]) begin
            st_d.aeoff  = AW'(dcf_pkg::preset_offset(psel, DEPTH));
            st_d.afoff  = AW'(dcf_pkg::preset_offset(psel, DEPTH));
            st_d.bitcnt = '0;
        end else if (shift_en && cfg_mode) begin
            // LSB first: shift in at the top, first bit ends at bit 0
            if (st_q.bitcnt < CW'(AW)) begin
                st_d.aeoff = {shift_din, st_q.aeoff[AW-1:1]};
            end else begin
                st_d.afoff = {shift_din, st_q.afoff[AW-1:1]};
            end
            st_d.bitcnt = (st_q.bitcnt == CW'(2 * AW - 1)) ? '0 : st_q.bitcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign waddr = st_q.bin[AW-1:0];
    assign wbin  = st_q.bin;
    assign wgray = st_q.gray;
    assign full  = st_q.full;
    assign afull = st_q.afull;
    assign half  = st_q.half;
    assign aeoff = st_q.aeoff;
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW:0]   wgray_s,
    input  logic [AW-1:0] aeoff,
    output logic          ren,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic          empty,
    output logic          aempty
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          empty;
        logic          aempty;
    } rd_st_t;

    rd_st_t st_d, st_q;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] cnt;

    always_comb begin
        st_d        = st_q;
        ren         = re & ~st_q.empty;
        st_d.bin    = st_q.bin + PW'(ren);
        st_d.gray   = PW'(dcf_pkg::bin2gray(32'(st_d.bin)));
        wbin_s      = PW'(dcf_pkg::gray2bin(32'(wgray_s)));
        cnt         = wbin_s - st_d.bin;
        st_d.empty  = (cnt == '0);
        st_d.aempty = (cnt <= PW'(aeoff));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.empty  <= 1'b1;
            st_q.aempty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr  = st_q.bin[AW-1:0];
    assign rbin   = st_q.bin;
    assign rgray  = st_q.gray;
    assign empty  = st_q.empty;
    assign aempty = st_q.aempty;
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
    parameter int DW = 16,
    parameter int AW = 10
) (
    input  logic          rst_n,
    input  logic          wclk,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic [1:0]    preset_sel,
    input  logic          cfg_mode,
    input  logic          shift_en,
    input  logic          shift_din,
    input  logic          rclk,
    input  logic          re,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          almost_empty,
    output logic          full,
    output logic          almost_full,
    output logic          half_full
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    logic          wen, ren;
    logic [AW-1:0] waddr, raddr, aeoff;
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] wgray_s, rgray_s;
    logic [DW-1:0] mem [DEPTH];

    dcf_wr_ctl #(.AW(AW)) u_wr (
        .clk(wclk), .rst_n(rst_n), .we(we),
        .psel({cfg_mode, preset_sel}), .cfg_mode(cfg_mode),
        .shift_en(shift_en), .shift_din(shift_din), .rgray_s(rgray_s),
        .wen(wen), .waddr(waddr), .wbin(wbin), .wgray(wgray),
        .full(full), .afull(almost_full), .half(half_full), .aeoff(aeoff)
    );

    dcf_rd_ctl #(.AW(AW)) u_rd (
        .clk(rclk), .rst_n(rst_n), .re(re), .wgray_s(wgray_s), .aeoff(aeoff),
        .ren(ren), .raddr(raddr), .rbin(rbin), .rgray(rgray),
        .empty(empty), .aempty(almost_empty)
    );

    dcf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
    dcf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

    always_ff @(posedge wclk) begin
        if (wen) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (ren) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int AW = 6
) (
    input logic        rst_n,
    input logic        wclk,
    input logic        rclk,
    input logic        we,
    input logic        re,
    input logic        full,
    input logic        empty,
    input logic        almost_full,
    input logic        almost_empty,
    input logic        half_full,
    input logic [AW:0] wbin,
    input logic [AW:0] rbin,
    input logic [AW:0] wgray,
    input logic [AW:0] rgray
);
    assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!rst_n)
        (we && full) |=> $stable(wbin));

    assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (!rst_n)
        (re && empty) |=> $stable(rbin));

    assert_wgray_step_R11: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    assert_rgray_step_R11: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);

    assert_full_half_R6: assert property (@(posedge wclk) disable iff (!rst_n)
        full |-> half_full);

    assert_full_afull_R8: assert property (@(posedge wclk) disable iff (!rst_n)
        full |-> almost_full);

    assert_empty_aempty_R7: assert property (@(posedge rclk) disable iff (!rst_n)
        empty |-> almost_empty);
endmodule

bind dcfifo_pflag dcf_checker #(.AW(AW)) u_chk (
    .rst_n(rst_n), .wclk(wclk), .rclk(rclk), .we(we), .re(re),
    .full(full), .empty(empty), .almost_full(almost_full),
    .almost_empty(almost_empty), .half_full(half_full),
    .wbin(wbin), .rbin(rbin), .wgray(wgray), .rgray(rgray)
);

// File: tb/tb_dcfifo_pflag.sv
`timescale 1ns/100ps
module tb_dcfifo_pflag;
    localparam int DW = 8;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          rst_n = 1'b0, wclk = 1'b0, rclk = 1'b0;
    logic          we = 1'b0, re = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [1:0]    preset_sel = '0;
    logic          cfg_mode = 1'b0, shift_en = 1'b0, shift_din = 1'b0;
    logic [DW-1:0] rdata;
    logic          empty, almost_empty, full, almost_full, half_full;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5   wclk = ~wclk;
    always #6.5 rclk = ~rclk;

    dcfifo_pflag #(.DW(DW), .AW(AW)) dut (
        .rst_n(rst_n), .wclk(wclk), .we(we), .wdata(wdata),
        .preset_sel(preset_sel), .cfg_mode(cfg_mode), .shift_en(shift_en),
        .shift_din(shift_din), .rclk(rclk), .re(re), .rdata(rdata),
        .empty(empty), .almost_empty(almost_empty), .full(full),
        .almost_full(almost_full), .half_full(half_full)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(logic [2:0] idx);
        @(negedge wclk);
        rst_n = 1'b0;
        {cfg_mode, preset_sel} = idx;
        repeat (4) @(negedge wclk);
        rst_n = 1'b1;
        repeat (4) @(negedge wclk);
        cfg_mode = 1'b0;
        preset_sel = '0;
    endtask

    task automatic wr(logic [DW-1:0] v);
        @(negedge wclk);
        we = 1'b1; wdata = v;
        @(negedge wclk);
        we = 1'b0;
    endtask

    task automatic rd();
        @(negedge rclk);
        re = 1'b1;
        @(negedge rclk);
        re = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
        repeat (4) @(negedge wclk);
    endtask

    // R1: flags after reset
    task automatic t_reset();
        do_reset(3'd0);
        chk("R1 empty", empty, 1);
        chk("R1 almost_empty", almost_empty, 1);
        chk("R1 full", full, 0);
        chk("R1 almost_full", almost_full, 0);
        chk("R1 half_full", half_full, 0);
    endtask

    // R2, R7 with preset 7
    task automatic t_order_aempty();
        for (int i = 0; i < 7; i++) wr(8'h10 + 8'(i));
        settle();
        chk("R5 empty clears", empty, 0);
        chk("R7 aempty at 7", almost_empty, 1);
        wr(8'h17);
        settle();
        chk("R7 aempty at 8", almost_empty, 0);
        for (int i = 0; i < 8; i++) begin
            rd();
            chk("R2 order", rdata, 8'h10 + 8'(i));
        end
        settle();
        chk("R5 empty after drain", empty, 1);
    endtask

    // R5, R6, R8, R3, R4 with preset 7 on a fresh FIFO
    task automatic t_fill_drain();
        do_reset(3'd0);
        for (int i = 1; i <= DEPTH; i++) begin
            wr(8'(i) ^ 8'hA5);
            if (i == 32) chk("R6 half at 32", half_full, 0);
            if (i == 33) chk("R6 half at 33", half_full, 1);
            if (i == 56) chk("R8 afull at 56", almost_full, 0);
            if (i == 57) chk("R8 afull at 57", almost_full, 1);
            if (i == 63) chk("R5 full at 63", full, 0);
            if (i == 64) chk("R5 full at 64", full, 1);
        end
        wr(8'hEE);
        chk("R3 full holds", full, 1);
        settle();
        for (int i = 1; i <= DEPTH; i++) begin
            rd();
            chk("R3 R2 drain data", rdata, 8'(i) ^ 8'hA5);
        end
        settle();
        chk("R3 no extra word", empty, 1);
        rd();
        chk("R4 rdata unchanged", rdata, 8'(DEPTH) ^ 8'hA5);
        wr(8'h5A);
        settle();
        rd();
        chk("R4 pointer unmoved", rdata, 8'h5A);
        settle();
    endtask

    // R10 serial load
    task automatic t_serial();
        logic [11:0] bits;
        do_reset(3'd0);
        @(negedge wclk);
        shift_en = 1'b1; shift_din = 1'b1;
        repeat (12) @(negedge wclk);
        shift_en = 1'b0;
        for (int i = 0; i < 4; i++) wr(8'(i));
        settle();
        chk("R10 no load without cfg_mode", almost_empty, 1);
        do_reset(3'd0);
        bits = {6'd10, 6'd3};
        for (int i = 0; i < 12; i++) begin
            @(negedge wclk);
            shift_en = 1'b1; cfg_mode = 1'b1; shift_din = bits[i];
        end
        @(negedge wclk);
        shift_en = 1'b0; cfg_mode = 1'b0;
        for (int i = 0; i < 3; i++) wr(8'(i));
        settle();
        chk("R10 aempty at 3", almost_empty, 1);
        wr(8'd3);
        settle();
        chk("R10 aempty at 4", almost_empty, 0);
        for (int i = 4; i < 53; i++) wr(8'(i));
        chk("R10 afull at 53", almost_full, 0);
        wr(8'd53);
        chk("R10 afull at 54", almost_full, 1);
    endtask

    // R9 presets, R1 reset with data present
    task automatic t_presets();
        do_reset(3'b010);
        chk("R1 empty after reset with data", empty, 1);
        chk("R1 full after reset with data", full, 0);
        for (int i = 0; i < 31; i++) wr(8'(i));
        settle();
        chk("R9 preset 31 aempty at 31", almost_empty, 1);
        wr(8'd31);
        chk("R9 preset 31 afull at 32", almost_full, 0);
        settle();
        chk("R9 preset 31 aempty at 32", almost_empty, 0);
        wr(8'd32);
        chk("R9 preset 31 afull at 33", almost_full, 1);
        do_reset(3'b101);
        chk("R9 clipped afull at 0", almost_full, 0);
        wr(8'h77);
        chk("R9 clipped afull at 1", almost_full, 1);
        settle();
        chk("R9 clipped aempty at 1", almost_empty, 1);
        rd();
        chk("R2 first word after reset", rdata, 8'h77);
    endtask

    initial begin
        t_reset();
        t_order_aempty();
        t_fill_drain();
        t_serial();
        t_presets();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule